// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder

This block adds or subtracts two normalized binary floating-point operands in a pipeline with four register stages. Each operand has a sign bit, an unsigned exponent of `EXP_W` bits and a mantissa of `MAN_W` bits. The mantissa carries its leading one explicitly, so a normalized operand has its mantissa MSB set. The value of an operand is (-1)^sign × (mantissa / 2^MAN_W) × 2^exponent.

The four stages run in a fixed order:
1. Compare the two exponents by subtracting them.
2. Align the smaller operand by shifting its mantissa right.
3. Add or subtract the two mantissa magnitudes.
4. Normalize the sum, shifting right on a carry or left by its leading-zero count.

A new operand pair can be presented on every clock. A valid flag travels with the data, and there is no backpressure. Special values such as NaN, infinity and denormals are not handled, and there is no rounding.

Top module: `fpadder_pipe4`

## Requirements
- R1: A pair sampled with `in_valid`=1 on clock edge k gives its result on the outputs after edge k+3. `out_valid` equals `in_valid` delayed by four edges, and back-to-back pairs with gaps keep their pattern.
- R2: The larger exponent becomes the tentative result exponent. The other mantissa is shifted right by the exponent difference: exponents 3 and 2 give a shift of one position.
- R3: When the exponent difference is `MAN_W` or more, the smaller operand contributes zero, and the larger operand passes through unchanged.
- R4: `in_sub`=1 inverts the sign of operand b before the operation. Equal effective signs add the magnitudes, and unequal signs subtract the smaller magnitude from the larger. The result takes the sign of the larger magnitude, and when the exponents are equal the mantissas decide which magnitude is larger.
- R5: A carry out of the mantissa sum shifts the sum right by one bit and increments the exponent, modulo 2^`EXP_W`.
- R6: A sum with leading zeros is shifted left by the leading-zero count, and the exponent is decreased by that count. A count equal to the exponent yields exponent 0.
- R7: An exact zero result is encoded as sign 0, exponent 0 and mantissa 0. A leading-zero count larger than the exponent also flushes the result to this encoding.
- R8: Bits shifted out during alignment or during carry normalization are dropped, so results are truncated.
- R9: Reset (active-low `rst_n`, asynchronous) clears every valid bit, so `out_valid` is 0 during reset and until new valid pairs arrive.
- R10: Every valid nonzero result has its mantissa MSB set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid bits |
| in_valid | input | 1 | Operand pair present this cycle |
| in_sub | input | 1 | 1 = a − b, 0 = a + b |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | EXP_W | Exponent of operand a |
| a_man | input | MAN_W | Mantissa of operand a (MSB set) |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | EXP_W | Exponent of operand b |
| b_man | input | MAN_W | Mantissa of operand b (MSB set) |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_man | output | MAN_W | Result mantissa |

## Verification
Several cases are hard to reach from the ports because they need particular operand pairs:
- Two mantissas that nearly cancel, so the leading-zero count exceeds the small exponent and the result flushes to zero.
- Equal exponents where b has the larger mantissa, so the operands must swap on the mantissa comparison alone.
- A count that exactly equals the exponent, one step short of the flush.

The vector table holds hand-built pairs for each of these cases. It feeds them back to back at one per clock, so that neighbouring operations overlap in every stage. A directed test then applies a reset while data is in flight.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } fpa_op_e;
endpackage

// File: rtl/fpa_expcmp.sv
// Stage 1 logic: exponent subtraction and operand ordering by magnitude.
module fpa_expcmp
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 8
) (
    input  fpa_op_e          op,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MAN_W-1:0] a_man,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MAN_W-1:0] b_man,
    output logic             big_sign,
    output logic [EXP_W-1:0] big_exp,
    output logic [MAN_W-1:0] big_man,
    output logic             sml_sign,
    output logic [MAN_W-1:0] sml_man,
    output logic [EXP_W-1:0] shamt
);
    logic             b_eff_sign;
    logic [EXP_W:0]   diff_ab;
    logic             swap;

    always_comb begin
        b_eff_sign = b_sign ^ (op == OP_SUB);
        diff_ab    = {1'b0, a_exp} - {1'b0, b_exp};
        swap       = diff_ab[EXP_W] || ((diff_ab == '0) && (b_man > a_man));
        if (swap) begin
            big_sign = b_eff_sign;
            big_exp  = b_exp;
            big_man  = b_man;
            sml_sign = a_sign;
            sml_man  = a_man;
            shamt    = b_exp - a_exp;
        end else begin
            big_sign = a_sign;
            big_exp  = a_exp;
            big_man  = a_man;
            sml_sign = b_eff_sign;
            sml_man  = b_man;
            shamt    = diff_ab[EXP_W-1:0];
        end
    end
endmodule

// File: rtl/fpa_align.sv
// Stage 2 logic: right shift of the smaller mantissa, zero past the width.
module fpa_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 8
) (
    input  logic [MAN_W-1:0] man_in,
    input  logic [EXP_W-1:0] shamt,
    output logic [MAN_W-1:0] man_out
);
    localparam logic [EXP_W-1:0] LIMIT = EXP_W'(MAN_W);

    always_comb begin
        if (shamt >= LIMIT) begin
            man_out = '0;
        end else begin
            man_out = man_in >> shamt;
        end
    end
endmodule

// File: rtl/fpa_norm.sv
// Stage 4 logic: leading-zero count and normalization of the raw sum.
module fpa_norm #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 8
) (
    input  logic             sign_in,
    input  logic [EXP_W-1:0] exp_in,
    input  logic [MAN_W:0]   raw,
    output logic             sign_out,
    output logic [EXP_W-1:0] exp_out,
    output logic [MAN_W-1:0] man_out
);
    localparam int LZ_W = $clog2(MAN_W + 1);

    logic [LZ_W-1:0] lz;
    logic            found;

    always_comb begin
        lz    = LZ_W'(MAN_W);
        found = 1'b0;
        for (int i = MAN_W - 1; i >= 0; i--) begin
            if (!found && raw[i]) begin
                lz    = LZ_W'(MAN_W - 1 - i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        if (raw[MAN_W]) begin
            sign_out = sign_in;
            exp_out  = exp_in + 1'b1;
            man_out  = raw[MAN_W:1];
        end else if (!found || (EXP_W'(lz) > exp_in)) begin
            sign_out = 1'b0;
            exp_out  = '0;
            man_out  = '0;
        end else begin
            sign_out = sign_in;
            exp_out  = exp_in - EXP_W'(lz);
            man_out  = raw[MAN_W-1:0] << lz;
        end
    end
endmodule

// File: rtl/fpadder_pipe4.sv
module fpadder_pipe4
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sub,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MAN_W-1:0] a_man,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MAN_W-1:0] b_man,
    output logic             out_valid,
    output logic             out_sign,
    output logic [EXP_W-1:0] out_exp,
    output logic [MAN_W-1:0] out_man
);
    localparam int NSTG = 4;

    fpa_op_e op;
    assign op = fpa_op_e'(in_sub);

    // valid shift chain, one bit per stage
    logic [NSTG-1:0] vld_q;

    // stage 1 combinational / registered
    logic             c1_bs, c1_ss;
    logic [EXP_W-1:0] c1_be, c1_sh;
    logic [MAN_W-1:0] c1_bm, c1_sm;
    logic             s1_bs, s1_ss;
    logic [EXP_W-1:0] s1_be, s1_sh;
    logic [MAN_W-1:0] s1_bm, s1_sm;

    // stage 2
    logic [MAN_W-1:0] c2_al;
    logic             s2_bs, s2_ss;
    logic [EXP_W-1:0] s2_be;
    logic [MAN_W-1:0] s2_bm, s2_al;

    // stage 3
    logic [MAN_W:0]   c3_sum;
    logic             s3_sg;
    logic [EXP_W-1:0] s3_ex;
    logic [MAN_W:0]   s3_sum;

    // stage 4
    logic             c4_sg;
    logic [EXP_W-1:0] c4_ex;
    logic [MAN_W-1:0] c4_mn;

    fpa_expcmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
        .op       (op),
        .a_sign   (a_sign),
        .a_exp    (a_exp),
        .a_man    (a_man),
        .b_sign   (b_sign),
        .b_exp    (b_exp),
        .b_man    (b_man),
        .big_sign (c1_bs),
        .big_exp  (c1_be),
        .big_man  (c1_bm),
        .sml_sign (c1_ss),
        .sml_man  (c1_sm),
        .shamt    (c1_sh)
    );

    fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .man_in  (s1_sm),
        .shamt   (s1_sh),
        .man_out (c2_al)
    );

    always_comb begin
        if (s2_bs == s2_ss) begin
            c3_sum = {1'b0, s2_bm} + {1'b0, s2_al};
        end else begin
            c3_sum = {1'b0, s2_bm} - {1'b0, s2_al};
        end
    end

    fpa_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .sign_in  (s3_sg),
        .exp_in   (s3_ex),
        .raw      (s3_sum),
        .sign_out (c4_sg),
        .exp_out  (c4_ex),
        .man_out  (c4_mn)
    );

    // control register: only the valid bits are reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[NSTG-2:0], in_valid};
        end
    end

    // datapath registers, one bank after each sub-operation
    always_ff @(posedge clk) begin
        s1_bs  <= c1_bs;
        s1_be  <= c1_be;
        s1_bm  <= c1_bm;
        s1_ss  <= c1_ss;
        s1_sm  <= c1_sm;
        s1_sh  <= c1_sh;

        s2_bs  <= s1_bs;
        s2_be  <= s1_be;
        s2_bm  <= s1_bm;
        s2_ss  <= s1_ss;
        s2_al  <= c2_al;

        s3_sg  <= s2_bs;
        s3_ex  <= s2_be;
        s3_sum <= c3_sum;

        out_sign <= c4_sg;
        out_exp  <= c4_ex;
        out_man  <= c4_mn;
    end

    assign out_valid = vld_q[NSTG-1];
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [EXP_W-1:0] a_exp,
    input logic [EXP_W-1:0] b_exp,
    input logic             out_valid,
    input logic             out_sign,
    input logic [EXP_W-1:0] out_exp,
    input logic [MAN_W-1:0] out_man
);
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd4) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    assert_exp_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4 && out_valid && out_man != '0) |->
        ({1'b0, out_exp} <= (($past(a_exp, 4) > $past(b_exp, 4)) ?
                             {1'b0, $past(a_exp, 4)} : {1'b0, $past(b_exp, 4)}) + 1'b1));

    assert_zero_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_man == '0) |-> (!out_sign && out_exp == '0));

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |-> !out_valid);

    assert_msb_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_man != '0) |-> out_man[MAN_W-1]);
endmodule

bind fpadder_pipe4 fpa_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_exp     (a_exp),
    .b_exp     (b_exp),
    .out_valid (out_valid),
    .out_sign  (out_sign),
    .out_exp   (out_exp),
    .out_man   (out_man)
);

// File: tb/sim_fpadder_pipe4.sv
module sim_fpadder_pipe4;
    localparam int EW = 8;
    localparam int MW = 8;
    localparam int NV = 17;
    localparam int VW = 52;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_sub, a_sign, b_sign;
    logic [EW-1:0] a_exp, b_exp;
    logic [MW-1:0] a_man, b_man;
    logic          out_valid, out_sign;
    logic [EW-1:0] out_exp;
    logic [MW-1:0] out_man;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fpadder_pipe4 #(.EXP_W(EW), .MAN_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
        .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
        .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_man(out_man)
    );

    // {sub, as, ae, am, bs, be, bm, exp_sign, exp_exp, exp_man}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'd3,  8'h80, 1'b0, 8'd2,  8'h80, 1'b0, 8'd3,  8'hC0},
        {1'b0, 1'b0, 8'd3,  8'hC0, 1'b0, 8'd2,  8'h80, 1'b0, 8'd4,  8'h80},
        {1'b1, 1'b0, 8'd5,  8'h90, 1'b0, 8'd5,  8'h90, 1'b0, 8'd0,  8'h00},
        {1'b1, 1'b0, 8'd5,  8'hA0, 1'b0, 8'd5,  8'h90, 1'b0, 8'd2,  8'h80},
        {1'b1, 1'b0, 8'd4,  8'h80, 1'b0, 8'd6,  8'h80, 1'b1, 8'd5,  8'hC0},
        {1'b0, 1'b1, 8'd20, 8'hF0, 1'b0, 8'd10, 8'hFF, 1'b1, 8'd20, 8'hF0},
        {1'b0, 1'b0, 8'd10, 8'h80, 1'b0, 8'd3,  8'hFF, 1'b0, 8'd10, 8'h81},
        {1'b0, 1'b0, 8'd11, 8'h80, 1'b0, 8'd3,  8'hFF, 1'b0, 8'd11, 8'h80},
        {1'b1, 1'b0, 8'd1,  8'h90, 1'b0, 8'd1,  8'h88, 1'b0, 8'd0,  8'h00},
        {1'b0, 1'b1, 8'd7,  8'hC0, 1'b1, 8'd7,  8'hC0, 1'b1, 8'd8,  8'hC0},
        {1'b1, 1'b1, 8'd3,  8'h80, 1'b1, 8'd3,  8'h80, 1'b0, 8'd0,  8'h00},
        {1'b1, 1'b0, 8'd9,  8'h88, 1'b0, 8'd9,  8'hC8, 1'b1, 8'd8,  8'h80},
        {1'b1, 1'b0, 8'd5,  8'h90, 1'b0, 8'd5,  8'h8C, 1'b0, 8'd0,  8'h80},
        {1'b0, 1'b0, 8'd4,  8'h81, 1'b0, 8'd3,  8'h81, 1'b0, 8'd4,  8'hC1},
        {1'b0, 1'b0, 8'd4,  8'hFF, 1'b0, 8'd4,  8'h82, 1'b0, 8'd5,  8'hC0},
        {1'b1, 1'b1, 8'd6,  8'hA0, 1'b1, 8'd6,  8'h80, 1'b1, 8'd4,  8'h80},
        {1'b0, 1'b0, 8'd2,  8'h80, 1'b1, 8'd4,  8'h80, 1'b1, 8'd3,  8'hC0}
    };

    localparam string VREQ [NV] = '{
        "R2", "R5", "R7", "R6", "R4", "R3", "R2", "R3", "R7",
        "R4", "R7", "R4", "R6", "R8", "R8", "R4", "R4"
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic drive_idle();
        in_valid = 1'b0; in_sub = 1'b0;
        a_sign = 1'b0; a_exp = '0; a_man = '0;
        b_sign = 1'b0; b_exp = '0; b_man = '0;
    endtask

    task automatic drive_vec(input int i);
        {in_sub, a_sign, a_exp, a_man, b_sign, b_exp, b_man} = VEC[i][VW-1:17];
        in_valid = 1'b1;
    endtask

    task automatic check_result(input int i);
        chk(VREQ[i], 32'({out_sign, out_exp, out_man}), 32'(VEC[i][16:0]));
        if (VEC[i][7:0] != 8'h00) chk("R10", 32'(out_man[MW-1]), 32'd1);
    endtask

    initial begin
        rst_n = 1'b0;
        drive_idle();
        repeat (3) @(negedge clk);
        chk("R9", 32'(out_valid), 32'd0);
        rst_n = 1'b1;

        // full-throughput table walk; result of pair j seen at negedge j+4 (R1)
        for (int j = 0; j < NV + 4; j++) begin
            @(negedge clk);
            if (j >= 4) begin
                chk("R1", 32'(out_valid), 32'd1);
                check_result(j - 4);
            end else begin
                chk("R1", 32'(out_valid), 32'd0);
            end
            if (j < NV) drive_vec(j);
            else        drive_idle();
        end

        // R1: gap pattern 1,0,1 must reappear four edges later
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (j == 4 || j == 6) begin
                chk("R1", 32'(out_valid), 32'd1);
                check_result(j == 4 ? 1 : 3);
            end else if (j == 5 || j == 7) begin
                chk("R1", 32'(out_valid), 32'd0);
            end
            if (j == 0)      drive_vec(1);
            else if (j == 2) drive_vec(3);
            else             drive_idle();
        end

        // R9: reset while two pairs are in flight
        @(negedge clk); drive_vec(0);
        @(negedge clk); drive_vec(4);
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        #1;
        chk("R9", 32'(out_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk("R9", 32'(out_valid), 32'd0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule